// File: doc/BRIEF.md
# Double-Buffered Overlay Window Configuration Bank

This block keeps the placement and memory layout of five overlay windows for a display pipeline. Software writes a staging copy of each window's settings through a simple register port. The display side works only from a second, active copy. On every vertical sync strobe, each window's staging values move into its active copy in one step. A window can be frozen with a per-window protect bit while software is part-way through a multi-register update, so the pipeline never sees a mix of old and new settings.

Each window holds a buffer start and end address, a line offset (bytes skipped between lines), a page width (bytes fetched per line), an inclusive rectangle given by its top-left and bottom-right corners, and an enable bit. Windows 1 to 4 also carry a per-colour 4-bit alpha. A shared control word holds one DMA channel enable and one protect bit per window. Both take effect at once and are not double-buffered. For each window the block also reports, one cycle later, whether the pixel position on its x/y inputs falls inside that window's active rectangle.

Top module: `win_shadow_bank`

## Requirements
- R1: Window w's staged registers sit at address w*8 + k. k=0 is control (bit 0 = window enable). k=1 is buffer start and k=2 is buffer end (each uses bits [AW-1:0]). k=3 is size: page width in bits [OW-1:0] and line offset in bits [16+OW-1:16]. k=4 is top-left and k=5 is bottom-right, each with x in bits [CW-1:0] and y in bits [16+CW-1:16]. k=6 is alpha: blue in [3:0], green in [7:4] and red in [11:8]. rd_data shows the staged value of rd_addr one cycle after rd_addr is presented. Unused bits, offset 7 and addresses above the control word read as 0.
- R2: The control word sits at address NUM_WIN*8 (40). Channel enables are in bits [NUM_WIN-1:0] and protect bits are in [16+NUM_WIN-1:16]. It reads back as written and acts without waiting for a sync.
- R3: In a cycle where vsync is high, every window whose protect bit is clear copies all of its staged fields into its active copy. In every other cycle the active copies do not change, whatever is written.
- R4: A window whose protect bit is set keeps its active copy through vsync. Once the bit is cleared, the next vsync transfers the staged values.
- R5: Window 0 has no alpha. Writes to its offset 6 are ignored, the address reads as 0, and its active alpha field stays 0.
- R6: act_cfg gives window w in bits [w*CFG_W +: CFG_W]. Fields are packed from the LSB as: start(AW), end(AW), line offset(OW), page width(OW), top-left x(CW), top-left y(CW), bottom-right x(CW), bottom-right y(CW), alpha(12), enable(1). With the defaults CFG_W=147.
- R7: hit[w] is registered. It is 1 one cycle after px/py when tlx<=px<=brx and tly<=py<=bry against the active rectangle (all four edges inclusive), the active enable is 1, and channel enable w is 1. Otherwise it is 0.
- R8: Clearing a window's staged enable bit stops its hit only after the next vsync that the protect bit allows.
- R9: Synchronous reset clears every staged field, every active field, the control word, hit and rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AB | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AB | Register read address |
| rd_data | output | 32 | Staged register value, one cycle after rd_addr |
| vsync | input | 1 | Vertical sync strobe, one cycle wide |
| px | input | CW | Current pixel x position |
| py | input | CW | Current pixel y position |
| act_cfg | output | NUM_WIN*CFG_W | Active configuration of all windows |
| hit | output | NUM_WIN | Per-window point-in-window flags |

## Verification
The bench builds the block with its default parameters: five windows, 32-bit addresses, 13-bit size fields and 11-bit coordinates. With these values every window slot is instantiated, including window 0 with its alpha removed, and the control word lands at address 40 with the protect bits in bits 20 to 16. Rectangles are placed so that both the first and the last included pixel can be probed, as well as the pixel just outside on each side. Protected and unprotected transfers are run in the same sequence, so the bench sees the active copy hold, then move on the first sync after the protect bit clears.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int REG_W   = 32;
  localparam int ALPHA_W = 12;

  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_START = 3'd1,
    RG_END   = 3'd2,
    RG_SIZE  = 3'd3,
    RG_TL    = 3'd4,
    RG_BR    = 3'd5,
    RG_ALPHA = 3'd6,
    RG_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/win_hit_cmp.sv
module win_hit_cmp #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic [CW-1:0] tlx,
  input  logic [CW-1:0] tly,
  input  logic [CW-1:0] brx,
  input  logic [CW-1:0] bry,
  output logic          hit
);
  logic inside_x, inside_y;

  assign inside_x = (px >= tlx) && (px <= brx);
  assign inside_y = (py >= tly) && (py <= bry);

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= en && inside_x && inside_y;
  end
endmodule

// File: rtl/win_slot.sv
module win_slot
  import win_pkg::*;
#(
  parameter int AW        = 32,
  parameter int OW        = 13,
  parameter int CW        = 11,
  parameter bit HAS_ALPHA = 1'b1,
  localparam int CFG_W    = 2*AW + 2*OW + 4*CW + ALPHA_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_sel_e         wr_sel,
  input  logic [REG_W-1:0] wdata,
  input  reg_sel_e         rd_sel,
  output logic [REG_W-1:0] rdata,
  input  logic             vsync,
  input  logic             prot,
  input  logic             chan_en,
  input  logic [CW-1:0]    px,
  input  logic [CW-1:0]    py,
  output logic [CFG_W-1:0] act_cfg,
  output logic             hit
);
  logic               s_en, a_en;
  logic [AW-1:0]      s_start, s_end, a_start, a_end;
  logic [OW-1:0]      s_ofs, s_pgw, a_ofs, a_pgw;
  logic [CW-1:0]      s_tlx, s_tly, s_brx, s_bry;
  logic [CW-1:0]      a_tlx, a_tly, a_brx, a_bry;
  logic [ALPHA_W-1:0] s_alpha, a_alpha;

  // staging copy, written by the register port
  always_ff @(posedge clk) begin
    if (rst) begin
      s_en <= 1'b0; s_start <= '0; s_end <= '0; s_ofs <= '0; s_pgw <= '0;
      s_tlx <= '0; s_tly <= '0; s_brx <= '0; s_bry <= '0;
    end else if (wr) begin
      case (wr_sel)
        RG_CTRL:  s_en <= wdata[0];
        RG_START: s_start <= wdata[AW-1:0];
        RG_END:   s_end <= wdata[AW-1:0];
        RG_SIZE:  begin s_pgw <= wdata[OW-1:0]; s_ofs <= wdata[16+OW-1:16]; end
        RG_TL:    begin s_tlx <= wdata[CW-1:0]; s_tly <= wdata[16+CW-1:16]; end
        RG_BR:    begin s_brx <= wdata[CW-1:0]; s_bry <= wdata[16+CW-1:16]; end
        default:  ;
      endcase
    end
  end

  generate
    if (HAS_ALPHA) begin : g_alpha
      always_ff @(posedge clk) begin
        if (rst)                        s_alpha <= '0;
        else if (wr && wr_sel == RG_ALPHA) s_alpha <= wdata[ALPHA_W-1:0];
      end
    end else begin : g_no_alpha
      assign s_alpha = '0;
    end
  endgenerate

  // active copy, loaded at vsync unless protected
  always_ff @(posedge clk) begin
    if (rst) begin
      a_en <= 1'b0; a_start <= '0; a_end <= '0; a_ofs <= '0; a_pgw <= '0;
      a_tlx <= '0; a_tly <= '0; a_brx <= '0; a_bry <= '0; a_alpha <= '0;
    end else if (vsync && !prot) begin
      a_en <= s_en; a_start <= s_start; a_end <= s_end; a_ofs <= s_ofs;
      a_pgw <= s_pgw; a_tlx <= s_tlx; a_tly <= s_tly; a_brx <= s_brx;
      a_bry <= s_bry; a_alpha <= s_alpha;
    end
  end

  always_comb begin
    rdata = '0;
    case (rd_sel)
      RG_CTRL:  rdata[0] = s_en;
      RG_START: rdata[AW-1:0] = s_start;
      RG_END:   rdata[AW-1:0] = s_end;
      RG_SIZE:  begin rdata[OW-1:0] = s_pgw; rdata[16+OW-1:16] = s_ofs; end
      RG_TL:    begin rdata[CW-1:0] = s_tlx; rdata[16+CW-1:16] = s_tly; end
      RG_BR:    begin rdata[CW-1:0] = s_brx; rdata[16+CW-1:16] = s_bry; end
      RG_ALPHA: rdata[ALPHA_W-1:0] = s_alpha;
      default:  ;
    endcase
  end

  assign act_cfg = {a_en, a_alpha, a_bry, a_brx, a_tly, a_tlx,
                    a_pgw, a_ofs, a_end, a_start};

  win_hit_cmp #(.CW(CW)) u_cmp (
    .clk(clk), .rst(rst), .en(a_en && chan_en), .px(px), .py(py),
    .tlx(a_tlx), .tly(a_tly), .brx(a_brx), .bry(a_bry), .hit(hit)
  );

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !vsync |=> $stable(act_cfg)); // R3
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
    (vsync && !prot) |=> (a_start == $past(s_start) && a_en == $past(s_en)
                          && a_brx == $past(s_brx))); // R3
  AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    prot |=> $stable(act_cfg)); // R4
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(a_en && chan_en)); // R7
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import win_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int AW      = 32,
  parameter int OW      = 13,
  parameter int CW      = 11,
  parameter int AB      = 6,
  localparam int CFG_W  = 2*AW + 2*OW + 4*CW + ALPHA_W + 1,
  localparam int WB     = AB - 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AB-1:0]            wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [AB-1:0]            rd_addr,
  output logic [REG_W-1:0]         rd_data,
  input  logic                     vsync,
  input  logic [CW-1:0]            px,
  input  logic [CW-1:0]            py,
  output logic [NUM_WIN*CFG_W-1:0] act_cfg,
  output logic [NUM_WIN-1:0]       hit
);
  localparam logic [AB-1:0] CTRL_ADDR = AB'(NUM_WIN * 8);

  logic [NUM_WIN-1:0] chan_q, prot_q;
  logic [REG_W-1:0]   slot_rd [NUM_WIN];
  logic [REG_W-1:0]   rd_next;
  logic [WB-1:0]      rd_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
      prot_q <= '0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      chan_q <= wr_data[NUM_WIN-1:0];
      prot_q <= wr_data[16+NUM_WIN-1:16];
    end
  end

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      win_slot #(.AW(AW), .OW(OW), .CW(CW), .HAS_ALPHA(w != 0)) u_slot (
        .clk(clk), .rst(rst),
        .wr(wr_en && (wr_addr < CTRL_ADDR) && (wr_addr[AB-1:3] == WB'(w))),
        .wr_sel(reg_sel_e'(wr_addr[2:0])), .wdata(wr_data),
        .rd_sel(reg_sel_e'(rd_addr[2:0])), .rdata(slot_rd[w]),
        .vsync(vsync), .prot(prot_q[w]), .chan_en(chan_q[w]),
        .px(px), .py(py),
        .act_cfg(act_cfg[w*CFG_W +: CFG_W]), .hit(hit[w])
      );
    end
  endgenerate

  assign rd_win = rd_addr[AB-1:3];

  always_comb begin
    rd_next = '0;
    if (rd_addr == CTRL_ADDR) begin
      rd_next[NUM_WIN-1:0]       = chan_q;
      rd_next[16+NUM_WIN-1:16]   = prot_q;
    end else if (rd_addr < CTRL_ADDR) begin
      for (int i = 0; i < NUM_WIN; i++)
        if (rd_win == WB'(i)) rd_next = slot_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr > CTRL_ADDR) |-> rd_data == '0); // R1
  AST_W0_ALPHA_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr == AB'(6)) |-> rd_data == '0); // R5
endmodule

// File: tb/sim_win_shadow_bank.sv
module sim_win_shadow_bank;
  localparam int NW = 5, AW = 32, OW = 13, CW = 11, AB = 6;
  localparam int CFGW = 147;
  localparam int CTRL = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AB-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic vsync = 1'b0;
  logic [CW-1:0] px = '0, py = '0;
  logic [NW*CFGW-1:0] act_cfg;
  logic [NW-1:0] hit;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_shadow_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync), .px(px), .py(py),
    .act_cfg(act_cfg), .hit(hit)
  );

  // scoreboard for register reads
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        req = 1'b0, req_d = 1'b0;

  always @(posedge clk) req_d <= req;

  always @(negedge clk) begin
    if (req_d) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        failures++;
        $display("FAIL %s read: got %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string t);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AB'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_addr = AB'(a); req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic sync();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic probe(input int x, input int y, input int w, input bit e, input string t);
    @(negedge clk);
    px = CW'(x); py = CW'(y);
    @(negedge clk);
    chk(64'(hit[w]), 64'(e), t);
  endtask

  function automatic logic [63:0] fld(input int w, input int lsb, input int width);
    logic [63:0] v = '0;
    for (int i = 0; i < width; i++) v[i] = act_cfg[w*CFGW + lsb + i];
    return v;
  endfunction

  // field LSBs from R6
  localparam int F_START = 0, F_END = 32, F_OFS = 64, F_PGW = 77, F_TLX = 90,
                 F_TLY = 101, F_BRX = 112, F_BRY = 123, F_ALPHA = 134, F_EN = 146;

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(64'(hit), 0, "R9 hit after reset");
    chk(64'(|act_cfg), 0, "R9 active after reset");
    rd(CTRL, 32'h0, "R9 ctrl");
    rd(2*8 + 1, 32'h0, "R9 w2 start");

    // R1 staging writes and readback on window 1
    wr(8 + 0, 32'h1);
    wr(8 + 1, 32'h1000_0000);
    wr(8 + 2, 32'h1000_4000);
    wr(8 + 3, (32'h40 << 16) | 32'h280);
    wr(8 + 4, (32'd20 << 16) | 32'd10);
    wr(8 + 5, (32'd39 << 16) | 32'd29);
    wr(8 + 6, 32'hFABC);
    rd(8 + 0, 32'h1, "R1 ctrl");
    rd(8 + 1, 32'h1000_0000, "R1 start");
    rd(8 + 2, 32'h1000_4000, "R1 end");
    rd(8 + 3, (32'h40 << 16) | 32'h280, "R1 size");
    rd(8 + 4, (32'd20 << 16) | 32'd10, "R1 top-left");
    rd(8 + 5, (32'd39 << 16) | 32'd29, "R1 bottom-right");
    rd(8 + 6, 32'hABC, "R1 alpha masked");
    rd(8 + 7, 32'h0, "R1 offset 7");
    rd(47, 32'h0, "R1 above ctrl");
    chk(fld(1, F_START, 32), 0, "R3 no transfer before vsync");

    // R2 control word
    wr(CTRL, 32'h2);
    rd(CTRL, 32'h2, "R2 ctrl readback");
    probe(15, 25, 1, 1'b0, "R7 inactive before vsync");

    // R3 / R6 transfer
    sync();
    chk(fld(1, F_START, 32), 64'h1000_0000, "R6 start");
    chk(fld(1, F_END, 32), 64'h1000_4000, "R6 end");
    chk(fld(1, F_OFS, 13), 64'h40, "R6 line offset");
    chk(fld(1, F_PGW, 13), 64'h280, "R6 page width");
    chk(fld(1, F_TLX, 11), 10, "R6 tlx");
    chk(fld(1, F_TLY, 11), 20, "R6 tly");
    chk(fld(1, F_BRX, 11), 29, "R6 brx");
    chk(fld(1, F_BRY, 11), 39, "R6 bry");
    chk(fld(1, F_ALPHA, 12), 64'hABC, "R6 alpha");
    chk(fld(1, F_EN, 1), 1, "R3 enable moved");

    // R7 inclusive edges
    probe(10, 20, 1, 1'b1, "R7 top-left corner");
    probe(29, 39, 1, 1'b1, "R7 bottom-right corner");
    probe(30, 39, 1, 1'b0, "R7 right of rect");
    probe(9, 25, 1, 1'b0, "R7 left of rect");
    probe(15, 40, 1, 1'b0, "R7 below rect");
    probe(15, 19, 1, 1'b0, "R7 above rect");
    probe(15, 25, 2, 1'b0, "R7 other window");
    wr(CTRL, 32'h0);
    probe(15, 25, 1, 1'b0, "R7 channel disabled");
    wr(CTRL, 32'h2);
    probe(15, 25, 1, 1'b1, "R7 channel enabled");

    // R5 window 0 alpha absent
    wr(6, 32'hFFF);
    rd(6, 32'h0, "R5 w0 alpha reads zero");
    sync();
    chk(fld(0, F_ALPHA, 12), 0, "R5 w0 active alpha");

    // R4 protect
    wr(CTRL, 32'h2 | (32'h2 << 16));
    rd(CTRL, 32'h0002_0002, "R2 protect readback");
    wr(8 + 1, 32'h2000_0000);
    sync();
    chk(fld(1, F_START, 32), 64'h1000_0000, "R4 held while protected");
    wr(CTRL, 32'h2);
    chk(fld(1, F_START, 32), 64'h1000_0000, "R4 unchanged before vsync");
    sync();
    chk(fld(1, F_START, 32), 64'h2000_0000, "R4 moved after unprotect");

    // R8 enable clear takes effect on allowed transfer
    wr(8 + 0, 32'h0);
    probe(15, 25, 1, 1'b1, "R8 hit before vsync");
    sync();
    probe(15, 25, 1, 1'b0, "R8 hit gone after vsync");
    wr(8 + 0, 32'h1);
    sync();
    wr(CTRL, 32'h2 | (32'h2 << 16));
    wr(8 + 0, 32'h0);
    sync();
    probe(15, 25, 1, 1'b1, "R8 protected keeps hit");
    wr(CTRL, 32'h2);
    sync();
    probe(15, 25, 1, 1'b0, "R8 cleared after unprotect");

    repeat (3) @(negedge clk);
    chk(64'(exp_q.size()), 0, "R1 scoreboard drained");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule